// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block gathers event reports from a network controller and holds them in an eleven-bit status register. The reports come from the receive and transmit DMA engines and from two small frame coprocessors, one on each path. Several bits are not simple pulses. Each of these has a detector in the block:

- a per-frame byte accumulator that raises an early-receive flag;
- two response watchdogs for checksum requests;
- a free-slot calculation on a receive buffer ring;
- a check of the transmit descriptor tag;
- decoding of coprocessor writes to fixed internal addresses.

Software reaches the block through a one-bit-select register port. With select 0, a read returns the status word and clears it at that edge, and a write clears each status bit where the write data holds a one. With select 1 the port reads and writes an enable mask. The single interrupt output is raised while any enabled status bit is set.

Top module: `nicIrqStatus`

## Requirements
- R1: After reset, every status bit and every mask bit is 0, `regRdata` reads 0 and `irqOut` is low.
- R2: A cycle with `regRd`=1 and `regSel`=0 returns the current status on `regRdata` and clears status bits 10..1 at that clock edge. A cycle with `regWr`=1 and `regSel`=0 clears each status bit whose `regWdata` bit is 1 and leaves the others unchanged. Set bits otherwise hold their value.
- R3: When a bit's set event and a clear (by read, by write-one, or by the bit-10 self-clear) fall in the same cycle, the bit ends up set.
- R4: A `rxQ1Done` pulse sets bit 8 and a `rxQ2Done` pulse sets bit 9.
- R5: While `earlyThresh` is nonzero, bit 10 sets on the beat where the bytes accumulated for the current frame first reach or pass `earlyThresh`. The sum counts `rxBeatBytes` on each `rxBeatValid` cycle and saturates. A `rxQ1Done` pulse zeroes the sum, ignores any beat in that same cycle, and clears bit 10.
- R6: A `rxCsumReq` pulse starts a response window for the receive coprocessor. If no `rxCsumAck` is sampled on any of the 16 following clock edges, bit 7 sets at the 16th edge. A new request restarts the window.
- R7: Bit 5 sets under either of two conditions: a `txCsumAck` arrives with `txCsumFail`=1, or a `txCsumReq` gets no `txCsumAck` within its 16-edge window (same timing as R6).
- R8: On a `rxQ2Fetch` cycle, bit 6 sets when (`rxQ2Prod` − `rxQ2Cons`) modulo 2^IDX_W is less than `rxQ2LowThresh`. Outside fetch cycles, the index values have no effect.
- R9: On a `txDescValid` cycle, a `txDescId` other than 4'b1011 sets bit 3 when `txDescHiPri`=1 and bit 4 when it is 0. The value 4'b1011 sets neither bit.
- R10: A `rxCpWr` to address 0x0E sets bit 2, and a `txCpWr` to address 0x0F sets bit 1. A write to any other address sets nothing.
- R11: With `regSel`=1, writes load mask bits 10..1 and reads return them with bit 0 as 0. `irqOut` is high exactly when some status bit in 10..1 and the same mask bit are both 1. Status bit 0 reads back as `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects status, 1 selects mask |
| regWdata | input | 11 | Write data |
| regRdata | output | 11 | Read data of the selected register |
| irqOut | output | 1 | Summary interrupt |
| rxBeatValid | input | 1 | Receive DMA moved bytes this cycle |
| rxBeatBytes | input | BEAT_W | Bytes moved in this beat |
| earlyThresh | input | BYTE_CW | Early-receive byte threshold, 0 disables |
| rxQ1Done | input | 1 | Completion written to receive queue 1 |
| rxQ2Done | input | 1 | Completion written to receive queue 2 |
| rxCsumReq | input | 1 | Receive checksum request to coprocessor |
| rxCsumAck | input | 1 | Receive coprocessor response |
| txCsumReq | input | 1 | Transmit checksum request to coprocessor |
| txCsumAck | input | 1 | Transmit coprocessor response |
| txCsumFail | input | 1 | Qualifies txCsumAck as "cannot compute" |
| rxQ2Fetch | input | 1 | Buffer descriptor fetch from receive ring 2 |
| rxQ2Prod | input | IDX_W | Ring 2 producer index |
| rxQ2Cons | input | IDX_W | Ring 2 consumer index |
| rxQ2LowThresh | input | IDX_W | Low-buffer threshold |
| txDescValid | input | 1 | Transmit descriptor tag is valid |
| txDescHiPri | input | 1 | Descriptor is high priority |
| txDescId | input | 4 | Descriptor tag |
| rxCpWr | input | 1 | Receive coprocessor write strobe |
| rxCpAddr | input | CP_AW | Receive coprocessor write address |
| txCpWr | input | 1 | Transmit coprocessor write strobe |
| txCpAddr | input | CP_AW | Transmit coprocessor write address |

## Verification
Two functions can land on the same edge: a detector setting a status bit, and software clearing the register by a read or a write-one. The bench provokes this in three ways. It pulses `rxQ1Done` in the same cycle as a status read. It pulses `rxQ1Done` together with a write-one to bit 8. It also lets a random phase overlap read, write-one and event strobes freely. The outcome is judged against a behavioural model that applies the clear first and the set second. The model is compared with `regRdata` and `irqOut` on every clock.

// File: rtl/nicIrqPkg.sv
package nicIrqPkg;
  localparam int NUM_BITS = 11;

  // status bit positions
  localparam int B_TXCP   = 1;
  localparam int B_RXCP   = 2;
  localparam int B_TXHI   = 3;
  localparam int B_TXLO   = 4;
  localparam int B_TXCS   = 5;
  localparam int B_RXLOW  = 6;
  localparam int B_RXTMO  = 7;
  localparam int B_RXQ1   = 8;
  localparam int B_RXQ2   = 9;
  localparam int B_EARLY  = 10;

  localparam logic [3:0] DESC_TAG_OK   = 4'b1011;
  localparam logic [7:0] RXCP_IRQ_ADDR = 8'h0E;
  localparam logic [7:0] TXCP_IRQ_ADDR = 8'h0F;

  typedef struct packed {
    logic                earlyClr;
    logic                rdClr;
    logic                w1c;
    logic                maskWr;
    logic [NUM_BITS-1:0] setVec;
  } ctrlStrobes_t;
endpackage

// File: rtl/nicIrqWatchdog.sv
module nicIrqWatchdog #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  input  logic ack,
  output logic expired
);
  localparam int CW = ($clog2(TIMEOUT) < 1) ? 1 : $clog2(TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (req) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (ack || cnt == LAST) active <= 1'b0;
      else                    cnt    <= cnt + 1'b1;
    end
  end

  assign expired = active && !req && !ack && (cnt == LAST);
endmodule

// File: rtl/nicIrqCtrl.sv
module nicIrqCtrl
  import nicIrqPkg::*;
#(
  parameter int BYTE_CW = 16,
  parameter int BEAT_W  = 8,
  parameter int IDX_W   = 4,
  parameter int TIMEOUT = 16,
  parameter int CP_AW   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regRd,
  input  logic               regWr,
  input  logic               regSel,
  input  logic               rxBeatValid,
  input  logic [BEAT_W-1:0]  rxBeatBytes,
  input  logic [BYTE_CW-1:0] earlyThresh,
  input  logic               rxQ1Done,
  input  logic               rxQ2Done,
  input  logic               rxCsumReq,
  input  logic               rxCsumAck,
  input  logic               txCsumReq,
  input  logic               txCsumAck,
  input  logic               txCsumFail,
  input  logic               rxQ2Fetch,
  input  logic [IDX_W-1:0]   rxQ2Prod,
  input  logic [IDX_W-1:0]   rxQ2Cons,
  input  logic [IDX_W-1:0]   rxQ2LowThresh,
  input  logic               txDescValid,
  input  logic               txDescHiPri,
  input  logic [3:0]         txDescId,
  input  logic               rxCpWr,
  input  logic [CP_AW-1:0]   rxCpAddr,
  input  logic               txCpWr,
  input  logic [CP_AW-1:0]   txCpAddr,
  output ctrlStrobes_t       strb
);
  localparam int SUM_W = BYTE_CW + 1;

  // per-frame byte accumulator
  logic [BYTE_CW-1:0] byteCnt;
  logic [SUM_W-1:0]   byteSum;
  logic [BYTE_CW-1:0] byteNext;
  logic               earlyHit;

  assign byteSum  = {1'b0, byteCnt} + SUM_W'(rxBeatBytes);
  assign byteNext = byteSum[BYTE_CW] ? '1 : byteSum[BYTE_CW-1:0];
  assign earlyHit = rxBeatValid && !rxQ1Done && (earlyThresh != '0) &&
                    (byteCnt < earlyThresh) && (byteNext >= earlyThresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            byteCnt <= '0;
    else if (rxQ1Done)    byteCnt <= '0;
    else if (rxBeatValid) byteCnt <= byteNext;
  end

  // coprocessor response watchdogs
  logic [1:0] wdReq, wdAck, wdExp;
  assign wdReq = {txCsumReq, rxCsumReq};
  assign wdAck = {txCsumAck, rxCsumAck};

  for (genvar g = 0; g < 2; g++) begin : g_wd
    nicIrqWatchdog #(.TIMEOUT(TIMEOUT)) wd_i (
      .clk    (clk),
      .rstN   (rstN),
      .req    (wdReq[g]),
      .ack    (wdAck[g]),
      .expired(wdExp[g])
    );
  end

  // ring 2 free-slot check
  logic [IDX_W-1:0] availCnt;
  logic             lowHit;
  assign availCnt = rxQ2Prod - rxQ2Cons;
  assign lowHit   = rxQ2Fetch && (availCnt < rxQ2LowThresh);

  // descriptor tag check
  logic tagBad;
  assign tagBad = txDescValid && (txDescId != DESC_TAG_OK);

  always_comb begin
    strb                 = '0;
    strb.setVec[B_EARLY] = earlyHit;
    strb.setVec[B_RXQ2]  = rxQ2Done;
    strb.setVec[B_RXQ1]  = rxQ1Done;
    strb.setVec[B_RXTMO] = wdExp[0];
    strb.setVec[B_RXLOW] = lowHit;
    strb.setVec[B_TXCS]  = wdExp[1] || (txCsumAck && txCsumFail);
    strb.setVec[B_TXLO]  = tagBad && !txDescHiPri;
    strb.setVec[B_TXHI]  = tagBad && txDescHiPri;
    strb.setVec[B_RXCP]  = rxCpWr && (rxCpAddr == CP_AW'(RXCP_IRQ_ADDR));
    strb.setVec[B_TXCP]  = txCpWr && (txCpAddr == CP_AW'(TXCP_IRQ_ADDR));
    strb.earlyClr        = rxQ1Done;
    strb.rdClr           = regRd && !regSel;
    strb.w1c             = regWr && !regSel;
    strb.maskWr          = regWr && regSel;
  end
endmodule

// File: rtl/nicIrqDatapath.sv
module nicIrqDatapath
  import nicIrqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic                regSel,
  input  logic [NUM_BITS-1:0] regWdata,
  output logic [NUM_BITS-1:0] regRdata,
  output logic                irqOut,
  output logic [NUM_BITS-1:0] stsQ,
  output logic [NUM_BITS-1:0] maskQ
);
  localparam logic [NUM_BITS-1:0] STORE_MASK = {{(NUM_BITS-1){1'b1}}, 1'b0};

  logic [NUM_BITS-1:0] clrVec;

  always_comb begin
    clrVec = '0;
    if (strb.rdClr)    clrVec = '1;
    if (strb.w1c)      clrVec = clrVec | regWdata;
    if (strb.earlyClr) clrVec[B_EARLY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ  <= '0;
      maskQ <= '0;
    end else begin
      stsQ <= ((stsQ & ~clrVec) | strb.setVec) & STORE_MASK;
      if (strb.maskWr) maskQ <= regWdata & STORE_MASK;
    end
  end

  assign irqOut   = |(stsQ & maskQ);
  assign regRdata = regSel ? maskQ : (stsQ | NUM_BITS'(irqOut));
endmodule

// File: rtl/nicIrqStatus.sv
module nicIrqStatus
  import nicIrqPkg::*;
#(
  parameter int BYTE_CW = 16,
  parameter int BEAT_W  = 8,
  parameter int IDX_W   = 4,
  parameter int TIMEOUT = 16,
  parameter int CP_AW   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regRd,
  input  logic               regWr,
  input  logic               regSel,
  input  logic [10:0]        regWdata,
  output logic [10:0]        regRdata,
  output logic               irqOut,
  input  logic               rxBeatValid,
  input  logic [BEAT_W-1:0]  rxBeatBytes,
  input  logic [BYTE_CW-1:0] earlyThresh,
  input  logic               rxQ1Done,
  input  logic               rxQ2Done,
  input  logic               rxCsumReq,
  input  logic               rxCsumAck,
  input  logic               txCsumReq,
  input  logic               txCsumAck,
  input  logic               txCsumFail,
  input  logic               rxQ2Fetch,
  input  logic [IDX_W-1:0]   rxQ2Prod,
  input  logic [IDX_W-1:0]   rxQ2Cons,
  input  logic [IDX_W-1:0]   rxQ2LowThresh,
  input  logic               txDescValid,
  input  logic               txDescHiPri,
  input  logic [3:0]         txDescId,
  input  logic               rxCpWr,
  input  logic [CP_AW-1:0]   rxCpAddr,
  input  logic               txCpWr,
  input  logic [CP_AW-1:0]   txCpAddr
);
  ctrlStrobes_t        strb;
  logic [NUM_BITS-1:0] stsView;
  logic [NUM_BITS-1:0] maskView;

  nicIrqCtrl #(
    .BYTE_CW(BYTE_CW), .BEAT_W(BEAT_W), .IDX_W(IDX_W),
    .TIMEOUT(TIMEOUT), .CP_AW(CP_AW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regRd(regRd), .regWr(regWr), .regSel(regSel),
    .rxBeatValid(rxBeatValid), .rxBeatBytes(rxBeatBytes), .earlyThresh(earlyThresh),
    .rxQ1Done(rxQ1Done), .rxQ2Done(rxQ2Done),
    .rxCsumReq(rxCsumReq), .rxCsumAck(rxCsumAck),
    .txCsumReq(txCsumReq), .txCsumAck(txCsumAck), .txCsumFail(txCsumFail),
    .rxQ2Fetch(rxQ2Fetch), .rxQ2Prod(rxQ2Prod), .rxQ2Cons(rxQ2Cons),
    .rxQ2LowThresh(rxQ2LowThresh),
    .txDescValid(txDescValid), .txDescHiPri(txDescHiPri), .txDescId(txDescId),
    .rxCpWr(rxCpWr), .rxCpAddr(rxCpAddr), .txCpWr(txCpWr), .txCpAddr(txCpAddr),
    .strb(strb)
  );

  nicIrqDatapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut),
    .stsQ(stsView), .maskQ(maskView)
  );
endmodule

// File: rtl/nicIrqChk.sv
module nicIrqChk
  import nicIrqPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input ctrlStrobes_t        strb,
  input logic [NUM_BITS-1:0] stsQ,
  input logic [NUM_BITS-1:0] maskQ,
  input logic                irqOut,
  input logic                rxCsumReq,
  input logic                txDescValid,
  input logic [3:0]          txDescId
);
  // R2
  rd_clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdClr && strb.setVec == '0) |=> stsQ == '0);

  // R2
  no_spontaneous_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdClr || strb.w1c || strb.earlyClr) |=> ((stsQ & $past(stsQ)) == $past(stsQ)));

  // R3
  set_persists_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec != '0) |=> ((stsQ & $past(strb.setVec)) == $past(strb.setVec)));

  // R5
  early_self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.earlyClr && !strb.setVec[B_EARLY]) |=> !stsQ[B_EARLY]);

  // R6
  wd_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCsumReq |=> !strb.setVec[B_RXTMO]);

  // R9
  good_tag_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDescValid && txDescId == DESC_TAG_OK) |-> !(strb.setVec[B_TXHI] || strb.setVec[B_TXLO]));

  // R11
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (stsQ[NUM_BITS-1:1] != '0));

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irqOut);
endmodule

bind nicIrqStatus nicIrqChk chk_i (
  .clk(clk), .rstN(rstN), .strb(strb), .stsQ(stsView), .maskQ(maskView),
  .irqOut(irqOut), .rxCsumReq(rxCsumReq), .txDescValid(txDescValid), .txDescId(txDescId)
);

// File: tb/nicIrqStatus_tb_top.sv
module nicIrqStatus_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        regRd = 0, regWr = 0, regSel = 0;
  logic [10:0] regWdata = 0;
  logic [10:0] regRdata;
  logic        irqOut;
  logic        rxBeatValid = 0;
  logic [7:0]  rxBeatBytes = 0;
  logic [15:0] earlyThresh = 0;
  logic        rxQ1Done = 0, rxQ2Done = 0;
  logic        rxCsumReq = 0, rxCsumAck = 0;
  logic        txCsumReq = 0, txCsumAck = 0, txCsumFail = 0;
  logic        rxQ2Fetch = 0;
  logic [3:0]  rxQ2Prod = 0, rxQ2Cons = 0, rxQ2LowThresh = 0;
  logic        txDescValid = 0, txDescHiPri = 0;
  logic [3:0]  txDescId = 0;
  logic        rxCpWr = 0, txCpWr = 0;
  logic [7:0]  rxCpAddr = 0, txCpAddr = 0;

  nicIrqStatus dut_i (.*);

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  string curTag = "R1";

  task automatic chk(string tag, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [10:0] mSts = 0, mMask = 0;
  int mBytes = 0, cyc = 0;
  bit rxPend = 0, txPend = 0;
  int rxDead = 0, txDead = 0;

  always @(posedge clk) begin
    logic [10:0] s, clr;
    int old;
    if (!rstN) begin
      mSts = 0; mMask = 0; mBytes = 0; rxPend = 0; txPend = 0; cyc = 0;
    end else begin
      cyc++;
      s = 0;
      if (rxQ1Done) s[8] = 1;
      if (rxQ2Done) s[9] = 1;
      if (rxQ1Done) mBytes = 0;
      else if (rxBeatValid) begin
        old = mBytes;
        mBytes = old + int'(rxBeatBytes);
        if (mBytes > 65535) mBytes = 65535;
        if (earlyThresh != 0 && old < int'(earlyThresh) && mBytes >= int'(earlyThresh)) s[10] = 1;
      end
      if (rxCsumReq) begin rxPend = 1; rxDead = cyc + 16; end
      else if (rxPend) begin
        if (rxCsumAck) rxPend = 0;
        else if (cyc == rxDead) begin s[7] = 1; rxPend = 0; end
      end
      if (txCsumReq) begin txPend = 1; txDead = cyc + 16; end
      else if (txPend) begin
        if (txCsumAck) txPend = 0;
        else if (cyc == txDead) begin s[5] = 1; txPend = 0; end
      end
      if (txCsumAck && txCsumFail) s[5] = 1;
      if (rxQ2Fetch && ((int'(rxQ2Prod) - int'(rxQ2Cons) + 16) % 16) < int'(rxQ2LowThresh)) s[6] = 1;
      if (txDescValid && txDescId != 4'b1011) begin
        if (txDescHiPri) s[3] = 1; else s[4] = 1;
      end
      if (rxCpWr && rxCpAddr == 8'h0E) s[2] = 1;
      if (txCpWr && txCpAddr == 8'h0F) s[1] = 1;
      clr = 0;
      if (regRd && !regSel) clr = 11'h7FF;
      if (regWr && !regSel) clr = clr | regWdata;
      if (rxQ1Done) clr[10] = 1;
      mSts = ((mSts & ~clr) | s) & 11'h7FE;
      if (regWr && regSel) mMask = regWdata & 11'h7FE;
    end
  end

  always @(posedge clk) begin
    logic irqExp;
    #5;
    if (rstN && !finished) begin
      irqExp = |(mSts & mMask);
      chk({curTag, " model irq"}, {10'd0, irqOut}, {10'd0, irqExp});
      chk({curTag, " model rdata"}, regRdata, regSel ? mMask : (mSts | {10'd0, irqExp}));
    end
  end

  task automatic tick();
    @(negedge clk);
    regRd = 0; regWr = 0; regSel = 0; rxBeatValid = 0; rxQ1Done = 0; rxQ2Done = 0;
    rxCsumReq = 0; rxCsumAck = 0; txCsumReq = 0; txCsumAck = 0; txCsumFail = 0;
    rxQ2Fetch = 0; txDescValid = 0; rxCpWr = 0; txCpWr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expSts(string tag, logic [10:0] exp);
    #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic rdClear();
    regRd = 1; tick(); expSts("R2 after read clear", 11'h000);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    #35;
    #1;
    curTag = "R1";
    chk("R1 reset rdata", regRdata, 11'h000);
    chk("R1 reset irq", {10'd0, irqOut}, 11'h000);
    @(negedge clk);
    rstN = 1;
    tick();
    expSts("R1 status after release", 11'h000);
    regSel = 1; expSts("R1 mask after reset", 11'h000); regSel = 0;

    curTag = "R11";
    regWr = 1; regSel = 1; regWdata = 11'h7FF; tick();
    regSel = 1; expSts("R11 mask readback bit0 zero", 11'h7FE); regSel = 0;

    curTag = "R4";
    rxQ1Done = 1; tick(); expSts("R4 q1 done bit8", 11'h101);
    rxQ2Done = 1; tick(); expSts("R4 q2 done bit9", 11'h301);
    rdClear();

    curTag = "R5";
    earlyThresh = 16'd100;
    rxBeatValid = 1; rxBeatBytes = 40; tick();
    rxBeatValid = 1; rxBeatBytes = 40; tick(); expSts("R5 below threshold", 11'h000);
    rxBeatValid = 1; rxBeatBytes = 40; tick(); expSts("R5 crossing sets bit10", 11'h401);
    rxBeatValid = 1; rxBeatBytes = 40; tick(); expSts("R5 no change after crossing", 11'h401);
    rxQ1Done = 1; tick(); expSts("R5 frame done clears bit10", 11'h101);
    rdClear();
    earlyThresh = 16'd80;
    rxBeatValid = 1; rxBeatBytes = 40; tick(); expSts("R5 half way", 11'h000);
    rxBeatValid = 1; rxBeatBytes = 40; tick(); expSts("R5 exact threshold sets", 11'h401);
    rxQ1Done = 1; tick(); rdClear();
    earlyThresh = 16'd0;
    rxBeatValid = 1; rxBeatBytes = 200; tick(); expSts("R5 zero threshold disabled", 11'h000);
    rxQ1Done = 1; tick(); rdClear();

    curTag = "R6";
    rxCsumReq = 1; tick();
    ticks(15); expSts("R6 before 16th edge", 11'h000);
    tick(); expSts("R6 timeout sets bit7", 11'h081);
    rdClear();
    rxCsumReq = 1; tick(); ticks(10);
    rxCsumAck = 1; tick(); ticks(10); expSts("R6 ack cancels", 11'h000);
    rxCsumReq = 1; tick(); ticks(10);
    rxCsumReq = 1; tick(); ticks(10); expSts("R6 restart delays", 11'h000);
    ticks(6); expSts("R6 restarted window expires", 11'h081);
    rdClear();

    curTag = "R7";
    txCsumReq = 1; tick(); ticks(15); expSts("R7 before timeout", 11'h000);
    tick(); expSts("R7 timeout sets bit5", 11'h021);
    rdClear();
    txCsumAck = 1; txCsumFail = 1; tick(); expSts("R7 fail response", 11'h021);
    rdClear();
    txCsumReq = 1; tick(); txCsumAck = 1; tick(); ticks(20); expSts("R7 good response quiet", 11'h000);

    curTag = "R8";
    rxQ2Prod = 4'd2; rxQ2Cons = 4'd14; rxQ2LowThresh = 4'd5;
    tick(); expSts("R8 no fetch no effect", 11'h000);
    rxQ2Fetch = 1; tick(); expSts("R8 wrapped avail 4 below 5", 11'h041);
    rdClear();
    rxQ2LowThresh = 4'd4; rxQ2Fetch = 1; tick(); expSts("R8 avail equal thresh quiet", 11'h000);

    curTag = "R9";
    txDescValid = 1; txDescHiPri = 1; txDescId = 4'b1011; tick(); expSts("R9 good tag", 11'h000);
    txDescValid = 1; txDescHiPri = 1; txDescId = 4'b1010; tick(); expSts("R9 bad hi tag", 11'h009);
    txDescValid = 1; txDescHiPri = 0; txDescId = 4'b0000; tick(); expSts("R9 bad lo tag", 11'h019);
    rdClear();

    curTag = "R10";
    rxCpWr = 1; rxCpAddr = 8'h0F; tick(); expSts("R10 rx wrong addr", 11'h000);
    rxCpWr = 1; rxCpAddr = 8'h0E; tick(); expSts("R10 rx addr 0E", 11'h005);
    txCpWr = 1; txCpAddr = 8'h0E; tick(); expSts("R10 tx wrong addr", 11'h005);
    txCpWr = 1; txCpAddr = 8'h0F; tick(); expSts("R10 tx addr 0F", 11'h007);
    rdClear();

    curTag = "R2";
    rxQ1Done = 1; rxQ2Done = 1; tick();
    regWr = 1; regWdata = 11'h100; tick(); expSts("R2 write-one clears bit8 only", 11'h201);
    regWr = 1; regWdata = 11'h000; tick(); expSts("R2 write zero no effect", 11'h201);

    curTag = "R3";
    regRd = 1; rxQ1Done = 1; tick(); expSts("R3 set beats read clear", 11'h101);
    regWr = 1; regWdata = 11'h100; rxQ1Done = 1; tick(); expSts("R3 set beats write-one", 11'h101);

    curTag = "R11";
    regWr = 1; regSel = 1; regWdata = 11'h000; tick();
    expSts("R11 masked status bit0 low", 11'h100);
    chk("R11 masked irq low", {10'd0, irqOut}, 11'h000);
    regWr = 1; regSel = 1; regWdata = 11'h100; tick();
    chk("R11 enabled irq high", {10'd0, irqOut}, 11'h001);
    rdClear();

    curTag = "R2 R3 random";
    regWr = 1; regSel = 1; regWdata = 11'h5AA; tick();
    for (int i = 0; i < 4000; i++) begin
      regRd       = ($urandom % 10) == 0;
      regWr       = ($urandom % 10) == 0;
      regSel      = ($urandom % 4) == 0;
      regWdata    = 11'($urandom);
      rxBeatValid = ($urandom % 3) == 0;
      rxBeatBytes = 8'($urandom);
      earlyThresh = 16'($urandom % 600);
      rxQ1Done    = ($urandom % 12) == 0;
      rxQ2Done    = ($urandom % 20) == 0;
      rxCsumReq   = ($urandom % 30) == 0;
      rxCsumAck   = ($urandom % 25) == 0;
      txCsumReq   = ($urandom % 30) == 0;
      txCsumAck   = ($urandom % 25) == 0;
      txCsumFail  = ($urandom % 3) == 0;
      rxQ2Fetch   = ($urandom % 6) == 0;
      rxQ2Prod    = 4'($urandom);
      rxQ2Cons    = 4'($urandom);
      rxQ2LowThresh = 4'($urandom);
      txDescValid = ($urandom % 8) == 0;
      txDescHiPri = 1'($urandom);
      txDescId    = (($urandom % 2) == 0) ? 4'b1011 : 4'($urandom);
      rxCpWr      = ($urandom % 8) == 0;
      rxCpAddr    = 8'h0C + 8'($urandom % 4);
      txCpWr      = ($urandom % 8) == 0;
      txCpAddr    = 8'h0D + 8'($urandom % 4);
      tick();
    end

    ticks(3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule